// File: doc/BRIEF.md
# Multi-Queue Network Receive Buffer

This block sits between an on-chip network port and a tile's local memory. Incoming 32-bit words arrive with a small queue identifier. Each word is stored in one of several shallow queues chosen by that identifier, not by which tile sent it. This lets several producers stream data in at the same time. They do not have to wait for the local program to reach the matching receive step. A per-queue ready vector tells the network which queues can take another word. A sender aimed at a full queue keeps its word until space frees up.

The execution side issues receive operations in program order. Each operation names a queue, a word count and a base memory address. A sequencer accepts one operation at a time. It then stalls until the named queue holds data, and moves one word per cycle into consecutive memory addresses. When the last word has been written it signals completion. Queues that the current operation does not name keep filling in the meantime, so data can arrive in any order relative to the receive program.

Top module: `rb_recv_buffer`

## Requirements
- R1: After reset every queue is empty (all `q_ready` bits high), `rcv_ready` is high, and `mem_we` and `rcv_done` are low.
- R2: Bit i of `q_ready` is low exactly while queue i holds DEPTH (default 2) words. A word offered on `net_data` with `net_valid` high and `net_qid`=i is stored only when bit i is high; a refused word is not stored.
- R3: Words leave each queue in the order they were stored.
- R4: A queue that the active receive does not name still accepts words while that receive is waiting or transferring.
- R5: A receive request (`rcv_valid` with `rcv_count` nonzero) is taken only in a cycle where `rcv_ready` is high. `rcv_ready` is low from the cycle after it is taken until the cycle after its last write. Requests offered while `rcv_ready` is low are ignored.
- R6: While a receive is active, `mem_we` is high in a cycle exactly when its named queue is non-empty. A word stored at one clock edge can be written in the next cycle, and no write occurs while the queue is empty.
- R7: The k-th word of a receive (k from 0) is written at address `rcv_addr`+k, modulo 2^ADDR_W, with one word per cycle at most.
- R8: `rcv_done` is a one-cycle pulse in the cycle after the last word of a receive is written, and `rcv_ready` is high in that cycle.
- R9: A receive with `rcv_count` of zero writes nothing and raises `rcv_done` in the next cycle.
- R10: When a queue holds one word and that word is popped in the same cycle a new word is offered to the same queue, both actions happen, and the new word is written in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| net_valid | input | 1 | Network offers a word |
| net_qid | input | 4 | Target queue of the offered word |
| net_data | input | 32 | Offered word |
| q_ready | output | 16 | Per-queue ready; bit i high when queue i has space |
| rcv_valid | input | 1 | Receive request present |
| rcv_qid | input | 4 | Queue the receive drains |
| rcv_count | input | 8 | Number of words to move |
| rcv_addr | input | 16 | First destination address |
| rcv_ready | output | 1 | Sequencer idle, request can be taken |
| rcv_done | output | 1 | Pulse after a receive completes |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 32 | Memory write data |

## Verification
A wrong queue pointer or counter shows up as a wrong `q_ready` bit in the same cycle. It can also show up as a word written out of order or duplicated when that queue is next drained. A bad sequencer count or address shows at once on `mem_addr`, or as `rcv_done` firing a cycle early or late. Every cycle the bench compares the ready vector, strobe, address, data and completion pulse against a queue model built from the requirements. Any divergence is therefore reported in the cycle it first reaches a port.

// File: rtl/rb_pkg.sv
package rb_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/rb_fifo.sv
module rb_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic              full_o,
    output logic              empty_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_state_t;

    fifo_state_t st_q, st_d;
    logic        do_push, do_pop;

    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign head_o  = st_q.mem[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            st_d.mem[st_q.wr] = data_i;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        if (do_push && !do_pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rb_seq.sv
module rb_seq
    import rb_pkg::*;
#(
    parameter int QID_W  = 4,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [QID_W-1:0]  req_qid_i,
    input  logic [CNT_W-1:0]  req_count_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    input  logic              sel_empty_i,
    input  logic [DATA_W-1:0] sel_head_i,
    output logic [QID_W-1:0]  cur_qid_o,
    output logic [CNT_W-1:0]  rem_o,
    output logic              pop_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    typedef struct packed {
        seq_state_e        state;
        logic [QID_W-1:0]  qid;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
        logic              done;
    } seq_t;

    seq_t sq_q, sq_d;
    logic pop;

    assign pop         = (sq_q.state == SEQ_RUN) && !sel_empty_i;
    assign req_ready_o = (sq_q.state == SEQ_IDLE);
    assign cur_qid_o   = sq_q.qid;
    assign rem_o       = sq_q.rem;
    assign pop_o       = pop;
    assign done_o      = sq_q.done;
    assign wr_addr_o   = sq_q.addr;
    assign wr_data_o   = sel_head_i;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        case (sq_q.state)
            SEQ_IDLE: begin
                if (req_valid_i) begin
                    if (req_count_i == '0) begin
                        sq_d.done = 1'b1;
                    end else begin
                        sq_d.state = SEQ_RUN;
                        sq_d.qid   = req_qid_i;
                        sq_d.addr  = req_addr_i;
                        sq_d.rem   = req_count_i;
                    end
                end
            end
            SEQ_RUN: begin
                if (pop) begin
                    sq_d.addr = sq_q.addr + 1'b1;
                    sq_d.rem  = sq_q.rem - 1'b1;
                    if (sq_q.rem == CNT_W'(1)) begin
                        sq_d.state = SEQ_IDLE;
                        sq_d.done  = 1'b1;
                    end
                end
            end
            default: sq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{state: SEQ_IDLE, qid: '0, addr: '0, rem: '0, done: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

endmodule

// File: rtl/rb_recv_buffer.sv
module rb_recv_buffer #(
    parameter int NUM_Q  = 16,
    parameter int DEPTH  = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    localparam int QID_W = $clog2(NUM_Q)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_valid,
    input  logic [QID_W-1:0]  net_qid,
    input  logic [DATA_W-1:0] net_data,
    output logic [NUM_Q-1:0]  q_ready,
    input  logic              rcv_valid,
    input  logic [QID_W-1:0]  rcv_qid,
    input  logic [CNT_W-1:0]  rcv_count,
    input  logic [ADDR_W-1:0] rcv_addr,
    output logic              rcv_ready,
    output logic              rcv_done,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    logic [DATA_W-1:0] heads [NUM_Q];
    logic [NUM_Q-1:0]  full_v;
    logic [NUM_Q-1:0]  empty_v;
    logic [QID_W-1:0]  cur_qid;
    logic [CNT_W-1:0]  seq_rem;
    logic              seq_pop;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        rb_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (net_valid && (net_qid == QID_W'(g))),
            .data_i  (net_data),
            .pop_i   (seq_pop && (cur_qid == QID_W'(g))),
            .head_o  (heads[g]),
            .full_o  (full_v[g]),
            .empty_o (empty_v[g])
        );
    end

    assign q_ready = ~full_v;
    assign mem_we  = seq_pop;

    rb_seq #(
        .QID_W  (QID_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (rcv_valid),
        .req_qid_i   (rcv_qid),
        .req_count_i (rcv_count),
        .req_addr_i  (rcv_addr),
        .req_ready_o (rcv_ready),
        .sel_empty_i (empty_v[cur_qid]),
        .sel_head_i  (heads[cur_qid]),
        .cur_qid_o   (cur_qid),
        .rem_o       (seq_rem),
        .pop_o       (seq_pop),
        .done_o      (rcv_done),
        .wr_addr_o   (mem_addr),
        .wr_data_o   (mem_wdata)
    );

endmodule

// File: rtl/rb_recv_buffer_chk.sv
module rb_recv_buffer_chk #(
    parameter int NUM_Q  = 16,
    parameter int QID_W  = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_Q-1:0]  q_ready,
    input logic              mem_we,
    input logic [QID_W-1:0]  cur_qid,
    input logic [CNT_W-1:0]  rem,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rcv_ready,
    input logic              rcv_done,
    input logic              rcv_valid,
    input logic [CNT_W-1:0]  rcv_count
);

    for (genvar i = 0; i < NUM_Q; i++) begin : g_full
        AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!q_ready[i] && !(mem_we && cur_qid == QID_W'(i))) |=> !q_ready[i]); // R2
    end

    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rcv_ready); // R5

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_valid && rcv_ready && rcv_count != '0) |=> !rcv_ready); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && rem != CNT_W'(1)) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R7

    AST_LAST_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && rem == CNT_W'(1)) |=> (rcv_done && rcv_ready)); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_done |-> (rcv_ready && !mem_we)); // R8

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_valid && rcv_ready && rcv_count == '0) |=> (rcv_done && !mem_we)); // R9

endmodule

bind rb_recv_buffer rb_recv_buffer_chk #(
    .NUM_Q  (NUM_Q),
    .QID_W  (QID_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_ready   (q_ready),
    .mem_we    (mem_we),
    .cur_qid   (cur_qid),
    .rem       (seq_rem),
    .mem_addr  (mem_addr),
    .rcv_ready (rcv_ready),
    .rcv_done  (rcv_done),
    .rcv_valid (rcv_valid),
    .rcv_count (rcv_count)
);

// File: tb/tb_rb_recv_buffer.sv
`timescale 1ns/1ps
module tb_rb_recv_buffer;

    localparam int NQ = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        net_valid = 1'b0;
    logic [3:0]  net_qid = '0;
    logic [31:0] net_data = '0;
    logic [15:0] q_ready;
    logic        rcv_valid = 1'b0;
    logic [3:0]  rcv_qid = '0;
    logic [7:0]  rcv_count = '0;
    logic [15:0] rcv_addr = '0;
    logic        rcv_ready, rcv_done, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;

    always #2.5 clk = ~clk;

    rb_recv_buffer dut (
        .clk(clk), .rst_n(rst_n),
        .net_valid(net_valid), .net_qid(net_qid), .net_data(net_data),
        .q_ready(q_ready),
        .rcv_valid(rcv_valid), .rcv_qid(rcv_qid), .rcv_count(rcv_count),
        .rcv_addr(rcv_addr), .rcv_ready(rcv_ready), .rcv_done(rcv_done),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic [31:0] mq [NQ][2];
    int          mcnt [NQ];
    bit          mbusy, mdone;
    logic [3:0]  mqid;
    logic [15:0] maddr;
    int          mrem;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] exp_ready();
        logic [15:0] r;
        for (int i = 0; i < NQ; i++) r[i] = (mcnt[i] < 2);
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NQ; i++) mcnt[i] = 0;
        mbusy = 0; mdone = 0; mqid = '0; maddr = '0; mrem = 0;
    endtask

    // Sample current outputs against the model, then advance the model over the coming edge.
    task automatic step();
        bit ew, acc, was_busy, ndone;
        #1;
        chk(q_ready == exp_ready(), "R2 q_ready", 64'(q_ready), 64'(exp_ready()));
        chk(rcv_ready == !mbusy, "R5 rcv_ready", 64'(rcv_ready), 64'(!mbusy));
        chk(rcv_done == mdone, "R8 rcv_done", 64'(rcv_done), 64'(mdone));
        ew = mbusy && (mcnt[mqid] > 0);
        chk(mem_we == ew, "R6 mem_we", 64'(mem_we), 64'(ew));
        if (ew && mem_we) begin
            chk(mem_addr == maddr, "R7 mem_addr", 64'(mem_addr), 64'(maddr));
            chk(mem_wdata == mq[mqid][0], "R3 mem_wdata", 64'(mem_wdata), 64'(mq[mqid][0]));
        end
        acc = net_valid && (mcnt[net_qid] < 2);
        was_busy = mbusy;
        ndone = 0;
        if (ew) begin
            mq[mqid][0] = mq[mqid][1];
            mcnt[mqid]--;
            maddr = maddr + 16'd1;
            if (mrem == 1) begin
                mbusy = 0;
                ndone = 1;
            end
            mrem--;
        end
        if (!was_busy && rcv_valid) begin
            if (rcv_count == 0) ndone = 1;
            else begin
                mbusy = 1; mqid = rcv_qid; maddr = rcv_addr; mrem = int'(rcv_count);
            end
        end
        if (acc) begin
            mq[net_qid][mcnt[net_qid]] = net_data;
            mcnt[net_qid]++;
        end
        mdone = ndone;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        net_valid = 0; rcv_valid = 0;
    endtask

    task automatic push(input logic [3:0] q, input logic [31:0] d);
        net_valid = 1; net_qid = q; net_data = d;
    endtask

    task automatic issue(input logic [3:0] q, input logic [7:0] n, input logic [15:0] a);
        rcv_valid = 1; rcv_qid = q; rcv_count = n; rcv_addr = a;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk(q_ready == 16'hFFFF, "R1 q_ready", 64'(q_ready), 64'hFFFF);
        chk(rcv_ready == 1'b1, "R1 rcv_ready", 64'(rcv_ready), 64'd1);
        chk(mem_we == 1'b0 && rcv_done == 1'b0, "R1 we/done", 64'({mem_we, rcv_done}), 64'd0);
        @(negedge clk);

        // R2: fill queue 3, third word refused
        push(4'd3, 32'hA1); step();
        push(4'd3, 32'hA2); step();
        #1 chk(q_ready[3] == 1'b0, "R2 full queue not ready", 64'(q_ready[3]), 64'd0);
        push(4'd3, 32'hA3); step();
        idle_in();

        // R4/R6: receive on empty queue 5 blocks while queue 7 fills
        issue(4'd5, 8'd3, 16'h0040); step();
        idle_in();
        push(4'd7, 32'h71); step();
        push(4'd7, 32'h72); step();
        idle_in(); step();
        #1 chk(mem_we == 1'b0, "R6 blocked no write", 64'(mem_we), 64'd0);
        chk(q_ready[7] == 1'b0, "R4 other queue filled during receive", 64'(q_ready[7]), 64'd0);
        for (int k = 0; k < 3; k++) begin
            push(4'd5, 32'h50 + 32'(k)); step();
        end
        idle_in();
        repeat (3) step();

        // drain 3 (only A1, A2 stored) and 7
        issue(4'd3, 8'd2, 16'h0100); step();
        idle_in(); repeat (3) step();
        issue(4'd7, 8'd2, 16'hFFFF); step();
        idle_in(); repeat (3) step();

        // R9: zero-count receive
        issue(4'd9, 8'd0, 16'h0300); step();
        idle_in();
        #1 chk(rcv_done == 1'b1 && mem_we == 1'b0, "R9 zero count done, no write",
               64'({rcv_done, mem_we}), 64'b10);
        step();

        // R10: push and pop on one-entry queue in the same cycle
        push(4'd2, 32'hB1); step();
        idle_in(); issue(4'd2, 8'd2, 16'h0200); step();
        idle_in(); push(4'd2, 32'hB2); step();
        idle_in();
        #1 chk(mem_we == 1'b1 && mem_wdata == 32'hB2 && mem_addr == 16'h0201,
               "R10 word pushed during pop written next", 64'({mem_we, mem_addr, mem_wdata}),
               64'({1'b1, 16'h0201, 32'hB2}));
        repeat (2) step();

        // Random phase: R2..R8
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            net_valid = ($urandom_range(0, 9) < 7);
            net_qid   = 4'($urandom_range(0, 15));
            net_data  = $urandom;
            rcv_valid = ($urandom_range(0, 9) < 4);
            rcv_qid   = 4'($urandom_range(0, 15));
            rcv_count = 8'($urandom_range(0, 4));
            rcv_addr  = 16'($urandom);
            step();
        end
        idle_in();
        repeat (2) step();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule